// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between the serial bus slave of a byte-addressable non-volatile memory and its cell array. When a write transaction opens, the slave hands over the starting word address. Each data byte that follows is captured into a one-page staging buffer at the current pointer. Only the in-page offset bits of the pointer advance, so a long burst wraps back to the start of the page and replaces bytes received earlier. A per-byte valid mask records which page slots were actually received.

When the transaction ends with STOP and at least one byte was captured, the write-protect input is sampled in that same cycle. If protection is off, a self-timed write cycle starts. During it, busy is raised for a parameterised number of system clocks, and every received slot is copied to the array through a simple write port in ascending offset order. Slots that were not received are left untouched in the array. If protection is on, or no byte arrived, or the transaction is aborted by a repeated START, nothing is written and the block is ready again at once. The resume pointer output always shows where the next access should continue.

Top module: `pageWriteBuffer`

## Requirements
- R1: A `startValid` pulse while idle and not busy loads `startAddr` into the pointer, and `ptrAddr` shows it from the next cycle. The same pulse clears every slot of the valid mask.
- R2: Each `byteValid` pulse in an open write stores `byteData` in the slot named by the low log2(PAGE_BYTES) pointer bits, then adds one to those bits only, wrapping within the page. The page bits of `ptrAddr` never change, so after a single byte at the last offset of a page, `ptrAddr` points to offset 0 of the same page.
- R3: A burst longer than PAGE_BYTES overwrites the earliest slots, and each slot is written to the array once, with its latest byte.
- R4: A `stopPulse` with at least one received byte and `wpPin` low in that cycle raises `busy` from the next cycle for exactly CYCLE_CLKS cycles.
- R5: During the write cycle, `memWe` pulses once for each received slot and for no other. The pulses come in ascending offset order, with `memAddr` = {page bits, offset} and `memData` = that slot's byte. Array locations in the page that were not received keep their contents.
- R6: If `wpPin` is high in the `stopPulse` cycle, `busy` stays low and nothing is written. A new `startValid` is accepted in the very next cycle.
- R7: A change of `wpPin` after the `stopPulse` cycle has no effect on a write cycle already started.
- R8: A `stopPulse` with no received byte, or an `abortPulse`, ends the transaction without a write cycle or array write, and `ptrAddr` keeps its value.
- R9: While `busy` is high, `startValid`, `byteValid`, `stopPulse` and `abortPulse` are ignored: `ptrAddr` is unchanged and no extra array write occurs.
- R10: `memWe` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | One-cycle pulse: a write transaction opens at `startAddr` |
| startAddr | input | ADDR_W | Word address sent by the bus master |
| byteValid | input | 1 | One-cycle pulse: a data byte was received |
| byteData | input | DATA_W | Received data byte |
| stopPulse | input | 1 | One-cycle pulse: STOP ended the transaction |
| abortPulse | input | 1 | One-cycle pulse: repeated START cut the transaction short |
| wpPin | input | 1 | Write protect, high blocks array writes |
| busy | output | 1 | High for the whole self-timed write cycle |
| memWe | output | 1 | Array write strobe |
| memAddr | output | ADDR_W | Array write address |
| memData | output | DATA_W | Array write data |
| ptrAddr | output | ADDR_W | Address at which the next access resumes |

## Verification
The assertions rely on three properties of the inputs. Each strobe is a one-cycle pulse. `stopPulse` and `abortPulse` never occur in the same cycle. CYCLE_CLKS is at least PAGE_BYTES, so the whole drain fits inside the busy window. The bench drives every strobe for exactly one clock, starting at a falling edge. It never overlaps STOP with an abort, and it builds the block with a cycle length a little above the page size. Under those conditions, the checks on busy duration, write ordering and pointer freezing hold.

// File: rtl/pwbPkg.sv
package pwbPkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_BUSY    = 2'd2
  } pwbState_t;

  typedef struct packed {
    logic load;   // capture start address, clear valid mask
    logic take;   // store one byte, advance in-page offset
    logic drain;  // present one slot to the array port
  } pwbStrobe_t;

endpackage

// File: rtl/pwbDatapath.sv
module pwbDatapath
  import pwbPkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  pwbStrobe_t                          strb,
  input  logic [$clog2(PAGE_BYTES)-1:0]       drainIdx,
  input  logic [ADDR_W-1:0]                   startAddr,
  input  logic [DATA_W-1:0]                   byteData,
  output logic                                anyValid,
  output logic [ADDR_W-1:0]                   ptrAddr,
  output logic                                memWe,
  output logic [ADDR_W-1:0]                   memAddr,
  output logic [DATA_W-1:0]                   memData
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0]     pageReg;
  logic [OFF_W-1:0]      offReg;
  logic [PAGE_BYTES-1:0] validMask;
  logic [DATA_W-1:0]     bufMem [PAGE_BYTES];

  // pointer: page bits are loaded once, only offset bits move
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      offReg  <= '0;
    end else if (strb.load) begin
      pageReg <= startAddr[ADDR_W-1:OFF_W];
      offReg  <= startAddr[OFF_W-1:0];
    end else if (strb.take) begin
      offReg  <= offReg + 1'b1;
    end
  end

  // one lane per page slot: data byte plus its valid flag
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gLane
    logic hit;
    assign hit = strb.take && (offReg == OFF_W'(g));

    always_ff @(posedge clk) begin
      if (hit) bufMem[g] <= byteData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          validMask[g] <= 1'b0;
      else if (strb.load) validMask[g] <= 1'b0;
      else if (hit)       validMask[g] <= 1'b1;
    end
  end

  assign anyValid = |validMask;
  assign ptrAddr  = {pageReg, offReg};

  always_comb begin
    memWe   = strb.drain && validMask[drainIdx];
    memAddr = {pageReg, drainIdx};
    memData = bufMem[drainIdx];
  end

  // R2: a stored byte never moves the page and marks its slot valid
  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> ($stable(pageReg) && validMask[$past(offReg)]));

  // R1: loading clears the mask
  p_load_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !anyValid);

endmodule

// File: rtl/pwbControl.sv
module pwbControl
  import pwbPkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 250000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startValid,
  input  logic                          byteValid,
  input  logic                          stopPulse,
  input  logic                          abortPulse,
  input  logic                          wpPin,
  input  logic                          anyValid,
  output pwbStrobe_t                    strb,
  output logic [$clog2(PAGE_BYTES)-1:0] drainIdx,
  output logic                          busy
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_CLKS - 1);

  pwbState_t        state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic             commitNow;

  assign commitNow = (state == ST_COLLECT) && stopPulse && !abortPulse
                     && anyValid && !wpPin;

  always_comb begin
    strb.load  = (state == ST_IDLE) && startValid;
    strb.take  = (state == ST_COLLECT) && byteValid && !stopPulse && !abortPulse;
    strb.drain = (state == ST_BUSY) && (32'(cnt) < PAGE_BYTES);
    drainIdx   = cnt[OFF_W-1:0];
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (startValid) stateNext = ST_COLLECT;
      ST_COLLECT: begin
        if (abortPulse)     stateNext = ST_IDLE;
        else if (stopPulse) stateNext = commitNow ? ST_BUSY : ST_IDLE;
      end
      ST_BUSY:    if (cnt == LAST_CNT) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_BUSY && cnt != LAST_CNT) cnt <= cnt + 1'b1;
      else                                     cnt <= '0;
    end
  end

  assign busy = (state == ST_BUSY);

  // R4: busy holds until the timer has run its full length
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != LAST_CNT) |=> busy);

  // R6: protect high at STOP never starts a cycle
  p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_COLLECT) && stopPulse && wpPin) |=> !busy);

  // R8: STOP with an empty page never starts a cycle
  p_empty_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_COLLECT) && stopPulse && !anyValid) |=> !busy);

  // R7: once started, protect changes cannot end the cycle early
  p_wp_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$stable(wpPin) && cnt != LAST_CNT) |=> busy);

endmodule

// File: rtl/pageWriteBuffer.sv
module pageWriteBuffer
  import pwbPkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stopPulse,
  input  logic              abortPulse,
  input  logic              wpPin,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] ptrAddr
);

  localparam int OFF_W = $clog2(PAGE_BYTES);

  pwbStrobe_t       strb;
  logic [OFF_W-1:0] drainIdx;
  logic             anyValid;

  pwbControl #(
    .PAGE_BYTES (PAGE_BYTES),
    .CYCLE_CLKS (CYCLE_CLKS)
  ) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .byteValid  (byteValid),
    .stopPulse  (stopPulse),
    .abortPulse (abortPulse),
    .wpPin      (wpPin),
    .anyValid   (anyValid),
    .strb       (strb),
    .drainIdx   (drainIdx),
    .busy       (busy)
  );

  pwbDatapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .drainIdx  (drainIdx),
    .startAddr (startAddr),
    .byteData  (byteData),
    .anyValid  (anyValid),
    .ptrAddr   (ptrAddr),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memData   (memData)
  );

  // R10: the array port only fires inside the write cycle
  p_we_only_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R9: the pointer is frozen while the cycle runs
  p_ptr_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(ptrAddr));

endmodule

// File: tb/sim_pageWriteBuffer.sv
module sim_pageWriteBuffer;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int PB    = 32;
  localparam int CYC   = 40;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startValid = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          byteValid = 1'b0;
  logic [DW-1:0] byteData = '0;
  logic          stopPulse = 1'b0;
  logic          abortPulse = 1'b0;
  logic          wpPin = 1'b0;
  logic          busy, memWe;
  logic [AW-1:0] memAddr, ptrAddr;
  logic [DW-1:0] memData;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] arr    [DEPTH];
  logic [DW-1:0] expArr [DEPTH];
  logic [DW-1:0] pend   [PB];
  logic [PB-1:0] pendV;
  logic [AW-1:0] curPtr;
  int            wrCount;
  int            lastWr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pageWriteBuffer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)) u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .stopPulse(stopPulse),
    .abortPulse(abortPulse), .wpPin(wpPin), .busy(busy), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .ptrAddr(ptrAddr));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // array model fed by the write port, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (!busy) begin
        errors++; checks++;
        $display("FAIL R10 actual=memWe_without_busy expected=none");
      end
      if (int'(memAddr) <= lastWr) begin
        errors++; checks++;
        $display("FAIL R5 actual=0x%0h expected=above_0x%0h", memAddr, lastWr);
      end
      lastWr = int'(memAddr);
      arr[memAddr] = memData;
      wrCount++;
    end
  end

  task automatic openWrite(input logic [AW-1:0] a);
    @(negedge clk); startValid = 1'b1; startAddr = a;
    @(negedge clk); startValid = 1'b0;
    curPtr = a; pendV = '0; wrCount = 0; lastWr = -1;
  endtask

  task automatic sendByte(input logic [DW-1:0] d);
    @(negedge clk); byteValid = 1'b1; byteData = d;
    @(negedge clk); byteValid = 1'b0;
    pend[curPtr[4:0]] = d; pendV[curPtr[4:0]] = 1'b1;
    curPtr[4:0] = curPtr[4:0] + 5'd1;
  endtask

  task automatic sendStop(input logic wpAtStop, input logic wpAfter);
    @(negedge clk); wpPin = wpAtStop; stopPulse = 1'b1;
    @(negedge clk); stopPulse = 1'b0; wpPin = wpAfter;
  endtask

  task automatic sendAbort();
    @(negedge clk); abortPulse = 1'b1;
    @(negedge clk); abortPulse = 1'b0;
  endtask

  function automatic void applyExpected();
    for (int i = 0; i < PB; i++)
      if (pendV[i]) expArr[{curPtr[AW-1:5], 5'(i)}] = pend[i];
  endfunction

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 10 * CYC) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic compareArr(input string tag);
    int bad = -1;
    for (int i = 0; i < DEPTH; i++)
      if (bad < 0 && arr[i] !== expArr[i]) bad = i;
    check(bad < 0, tag, (bad < 0) ? 0 : int'(arr[bad]), (bad < 0) ? 0 : int'(expArr[bad]));
  endtask

  task automatic tReset();
    check(busy === 1'b0, "R4 reset busy", busy, 0);
    check(memWe === 1'b0, "R10 reset memWe", memWe, 0);
  endtask

  task automatic tWrapPage();
    int n;
    openWrite(8'h3C);
    check(ptrAddr === 8'h3C, "R1 pointer load", ptrAddr, 8'h3C);
    for (int i = 0; i < 6; i++) sendByte(8'hA0 + 8'(i));
    check(ptrAddr === 8'h22, "R2 in-page wrap", ptrAddr, 8'h22);
    sendStop(1'b0, 1'b0);
    check(busy === 1'b1, "R4 busy after stop", busy, 1);
    waitIdle(n);
    check(n == CYC, "R4 busy length", n, CYC);
    applyExpected();
    check(wrCount == 6, "R5 write count", wrCount, 6);
    compareArr("R5 array contents");
  endtask

  task automatic tOverflow();
    int n;
    openWrite(8'h40);
    for (int i = 0; i < 34; i++) sendByte(8'h10 + 8'(i));
    sendStop(1'b0, 1'b0);
    waitIdle(n);
    applyExpected();
    check(wrCount == PB, "R3 one write per slot", wrCount, PB);
    check(expArr[8'h40] == 8'h30 && expArr[8'h41] == 8'h31, "R3 model overwrite", expArr[8'h40], 8'h30);
    compareArr("R3 overwritten slots");
  endtask

  task automatic tPartial();
    int n;
    openWrite(8'h85);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33);
    sendStop(1'b0, 1'b0);
    waitIdle(n);
    applyExpected();
    check(wrCount == 3, "R5 only received slots", wrCount, 3);
    compareArr("R5 untouched neighbours");
  endtask

  task automatic tSingleLast();
    int n;
    openWrite(8'h7F);
    sendByte(8'h5E);
    check(ptrAddr === 8'h60, "R2 byte at last offset", ptrAddr, 8'h60);
    sendStop(1'b0, 1'b0);
    waitIdle(n);
    applyExpected();
    compareArr("R5 single byte");
  endtask

  task automatic tProtected();
    openWrite(8'hC0);
    sendByte(8'hEE); sendByte(8'hEF);
    sendStop(1'b1, 1'b1);
    check(busy === 1'b0, "R6 no busy when protected", busy, 0);
    // new command accepted at once
    @(negedge clk); startValid = 1'b1; startAddr = 8'hD4;
    @(negedge clk); startValid = 1'b0;
    check(ptrAddr === 8'hD4, "R6 immediate new command", ptrAddr, 8'hD4);
    sendAbort();
    wpPin = 1'b0;
    repeat (3) @(negedge clk);
    check(wrCount == 0, "R6 nothing written", wrCount, 0);
    compareArr("R6 array unchanged");
  endtask

  task automatic tWpAfterStop();
    int n;
    openWrite(8'h08);
    sendByte(8'h9A); sendByte(8'h9B);
    sendStop(1'b0, 1'b1);
    check(busy === 1'b1, "R7 cycle started", busy, 1);
    waitIdle(n);
    wpPin = 1'b0;
    check(n == CYC, "R7 full cycle length", n, CYC);
    applyExpected();
    compareArr("R7 data committed");
  endtask

  task automatic tEmptyAndAbort();
    openWrite(8'h55);
    sendStop(1'b0, 1'b0);
    check(busy === 1'b0, "R8 empty stop no cycle", busy, 0);
    check(ptrAddr === 8'h55, "R8 pointer kept", ptrAddr, 8'h55);
    openWrite(8'h90);
    sendByte(8'h01); sendByte(8'h02);
    sendAbort();
    check(busy === 1'b0, "R8 abort no cycle", busy, 0);
    check(ptrAddr === 8'h92, "R8 pointer after abort", ptrAddr, 8'h92);
    repeat (3) @(negedge clk);
    check(wrCount == 0, "R8 nothing written", wrCount, 0);
    compareArr("R8 array unchanged");
  endtask

  task automatic tBusyIgnore();
    int n;
    logic [AW-1:0] held;
    openWrite(8'hA8);
    sendByte(8'h71);
    sendStop(1'b0, 1'b0);
    held = ptrAddr;
    @(negedge clk); startValid = 1'b1; startAddr = 8'h10;
    @(negedge clk); startValid = 1'b0; byteValid = 1'b1; byteData = 8'hFF;
    @(negedge clk); byteValid = 1'b0; stopPulse = 1'b1;
    @(negedge clk); stopPulse = 1'b0; abortPulse = 1'b1;
    @(negedge clk); abortPulse = 1'b0;
    waitIdle(n);
    check(ptrAddr === held, "R9 pointer frozen", ptrAddr, held);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R9 no second cycle", busy, 0);
    applyExpected();
    check(wrCount == 1, "R9 no extra writes", wrCount, 1);
    compareArr("R9 array contents");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      arr[i] = 8'(i) ^ 8'h5A;
      expArr[i] = 8'(i) ^ 8'h5A;
    end
    wrCount = 0; lastWr = -1; pendV = '0; curPtr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWrapPage();
    tOverflow();
    tPartial();
    tSingleLast();
    tProtected();
    tWpAfterStop();
    tEmptyAndAbort();
    tBusyIgnore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule